// File: doc/BRIEF.md
# Burst Beat Address Generator

This block walks through the beat addresses of one memory-mapped burst. A controller loads it with a start pulse and the burst description: start address, encoded length, beat size and burst kind. It then presents the current beat address on `addr_o`. On every cycle in which the beat strobe is high, the accepted beat retires and the next address appears on the following cycle. When the final beat is showing, `last_o` is raised. `busy_o` drops on the cycle after that beat is accepted.

Three address patterns are supported:

- **Repeat:** a single fixed location, used when draining a FIFO-style register.
- **Linear:** the address climbs with no rollover.
- **Folding:** the address stays inside an aligned block of beats × bytes-per-beat and returns to the block base when it runs off the top.

A folding request whose beat count is not 2, 4, 8 or 16 is flagged and walked as a linear burst. A new burst is only taken while the block is idle.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `busy_o`, `last_o` and `wrap_err_o` are 0 and `addr_o` is 0.
- R2: `len_i` holds the beat count minus one. A burst retires after exactly `len_i`+1 accepted beats, so `len_i`=0 gives a single beat with `last_o` high from the first cycle.
- R3: Kind code 0 (repeat): every beat of the burst shows the start address unchanged.
- R4: Kind codes 1 (linear) and 3 (handled as linear): each later beat address is the current address rounded down to the beat size plus the beat size, modulo 2^ADDR_W. The first beat shows the start address exactly, even when it is unaligned.
- R5: Kind code 2 (folding): each later address is the linear next address folded into the block of size (`len_i`+1)×2^`size_i` that holds the current address. For example, 4 beats of 4 bytes from 0x100 give 0x100, 0x104, 0x108, 0x10C.
- R6: Kind code 2 with `len_i` not equal to 1, 3, 7 or 15 drives `wrap_err_o` high while that burst is busy, and its addresses follow the linear rule of R4. `wrap_err_o` is 0 whenever the block is idle.
- R7: `size_i` is log2 of the bytes per beat: 0 means 1 byte and 7 means 128 bytes.
- R8: `last_o` is high exactly when the block is busy and no beats remain after the current one. Accepting a beat with `last_o` high clears `busy_o` on the next cycle. Accepting any other beat keeps `busy_o` high.
- R9: `start_i` is ignored while busy, and `beat_i` is ignored while idle. This also applies when both arrive in the same idle cycle: the burst is loaded and that beat does not count. While idle, `addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new burst (taken only when idle) |
| start_addr_i | input | ADDR_W | Address of the first beat |
| len_i | input | LEN_W | Beat count minus one |
| size_i | input | 3 | log2 of bytes per beat |
| kind_i | input | 2 | 0 repeat, 1 linear, 2 folding, 3 linear |
| beat_i | input | 1 | Current beat accepted this cycle |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |
| wrap_err_o | output | 1 | Current folding burst has an illegal length |

## Verification
The bench targets the fold point of a folding burst. It starts mid-block, at 8-byte and 128-byte sizes, so that a generator which forgot to fold would run past the block top, and one that folded to the wrong base would jump outside the block. Unaligned linear starts and a burst near the top of the address space are used to expose a missing round-down or a stray carry. Single-beat bursts, start pulses during a burst and beat strobes while idle or in the loading cycle target counters that are off by one and commands taken at the wrong time. Illegal folding lengths check that the flag is raised and that the addresses still climb linearly instead of folding on a bad mask.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [1:0] {
      BK_FIXED = 2'd0,
      BK_INCR  = 2'd1,
      BK_WRAP  = 2'd2,
      BK_RSVD  = 2'd3
   } burst_kind_e;

   localparam int SIZE_W    = 3;
   localparam int NUM_SIZES = 1 << SIZE_W;
   // Largest folding block: 16 beats of 128 bytes = 2^11 bytes
   localparam int MIN_ADDR_W = 12;
   localparam int MIN_LEN_W  = 4;
endpackage

// File: rtl/bag_len_check.sv
module bag_len_check
   import bag_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic [1:0]       kind_i,
   input  logic [LEN_W-1:0] len_i,
   output burst_kind_e      eff_kind_o,
   output logic             illegal_o
);
   logic low_ok;
   logic high_zero;
   logic len_ok;

   // Legal folding beat counts are 2, 4, 8, 16 (encoded 1, 3, 7, 15)
   always_comb begin
      case (len_i[3:0])
         4'd1, 4'd3, 4'd7, 4'd15: low_ok = 1'b1;
         default:                 low_ok = 1'b0;
      endcase
   end

   generate
      if (LEN_W > 4) begin : g_wide
         assign high_zero = (len_i[LEN_W-1:4] == '0);
      end else begin : g_narrow
         assign high_zero = 1'b1;
      end
   endgenerate

   assign len_ok = low_ok && high_zero;

   always_comb begin
      illegal_o  = 1'b0;
      eff_kind_o = BK_INCR;
      case (kind_i)
         2'd0: eff_kind_o = BK_FIXED;
         2'd2: begin
            if (len_ok) begin
               eff_kind_o = BK_WRAP;
            end else begin
               eff_kind_o = BK_INCR;
               illegal_o  = 1'b1;
            end
         end
         default: eff_kind_o = BK_INCR;
      endcase
   end
endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr
   import bag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input  logic [ADDR_W-1:0] cur_addr_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic [LEN_W-1:0]  len_i,
   input  burst_kind_e       kind_i,
   output logic [ADDR_W-1:0] nxt_addr_o,
   output logic [ADDR_W-1:0] wrap_mask_o
);
   logic [ADDR_W-1:0] lane_mask [NUM_SIZES];
   logic [ADDR_W-1:0] size_mask;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] linear;
   logic [ADDR_W-1:0] beats;
   logic [ADDR_W-1:0] folded;

   // Low-bit mask for each beat size
   generate
      for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
         assign lane_mask[g] = ADDR_W'((64'd1 << g) - 64'd1);
      end
   endgenerate

   assign size_mask = lane_mask[size_i];
   assign step      = size_mask + ADDR_W'(1);
   assign aligned   = cur_addr_i & ~size_mask;
   assign linear    = aligned + step;

   assign beats       = ADDR_W'(len_i) + ADDR_W'(1);
   assign wrap_mask_o = (beats << size_i) - ADDR_W'(1);
   assign folded      = (cur_addr_i & ~wrap_mask_o) | (linear & wrap_mask_o);

   always_comb begin
      case (kind_i)
         BK_FIXED: nxt_addr_o = cur_addr_i;
         BK_WRAP:  nxt_addr_o = folded;
         default:  nxt_addr_o = linear;
      endcase
   end
endmodule

// File: rtl/bag_beat_ctrl.sv
module bag_beat_ctrl
   import bag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [SIZE_W-1:0] size_i,
   input  burst_kind_e       kind_i,
   input  logic              illegal_i,
   input  logic              beat_i,
   input  logic [ADDR_W-1:0] nxt_addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W-1:0]  len_o,
   output logic [SIZE_W-1:0] size_o,
   output burst_kind_e       kind_o,
   output logic              busy_o,
   output logic              last_o,
   output logic              err_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  remain_q;
   logic [SIZE_W-1:0] size_q;
   burst_kind_e       kind_q;
   logic              busy_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         len_q    <= '0;
         remain_q <= '0;
         size_q   <= '0;
         kind_q   <= BK_FIXED;
         busy_q   <= 1'b0;
         err_q    <= 1'b0;
      end else if (!busy_q) begin
         if (start_i) begin
            addr_q   <= start_addr_i;
            len_q    <= len_i;
            remain_q <= len_i;
            size_q   <= size_i;
            kind_q   <= kind_i;
            busy_q   <= 1'b1;
            err_q    <= illegal_i;
         end
      end else if (beat_i) begin
         if (remain_q == '0) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
         end else begin
            remain_q <= remain_q - LEN_W'(1);
            addr_q   <= nxt_addr_i;
         end
      end
   end

   assign addr_o = addr_q;
   assign len_o  = len_q;
   assign size_o = size_q;
   assign kind_o = kind_q;
   assign busy_o = busy_q;
   assign last_o = busy_q && (remain_q == '0);
   assign err_o  = err_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [2:0]        size_i,
   input  logic [1:0]        kind_i,
   input  logic              beat_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o,
   output logic              busy_o,
   output logic              wrap_err_o
);
   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W too small for largest folding block");
      end
      if (LEN_W < MIN_LEN_W) begin : g_bad_len
         $error("burst_addr_gen: LEN_W must cover 16-beat bursts");
      end
   endgenerate

   burst_kind_e       in_kind;
   logic              in_illegal;
   burst_kind_e       cur_kind;
   logic [LEN_W-1:0]  cur_len;
   logic [SIZE_W-1:0] cur_size;
   logic [ADDR_W-1:0] nxt_addr;
   logic [ADDR_W-1:0] wrap_mask;

   bag_len_check #(.LEN_W(LEN_W)) u_len_check (
      .kind_i     (kind_i),
      .len_i      (len_i),
      .eff_kind_o (in_kind),
      .illegal_o  (in_illegal)
   );

   bag_next_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_next_addr (
      .cur_addr_i  (addr_o),
      .size_i      (cur_size),
      .len_i       (cur_len),
      .kind_i      (cur_kind),
      .nxt_addr_o  (nxt_addr),
      .wrap_mask_o (wrap_mask)
   );

   bag_beat_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_beat_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_addr_i (start_addr_i),
      .len_i        (len_i),
      .size_i       (size_i),
      .kind_i       (in_kind),
      .illegal_i    (in_illegal),
      .beat_i       (beat_i),
      .nxt_addr_i   (nxt_addr),
      .addr_o       (addr_o),
      .len_o        (cur_len),
      .size_o       (cur_size),
      .kind_o       (cur_kind),
      .busy_o       (busy_o),
      .last_o       (last_o),
      .err_o        (wrap_err_o)
   );
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              beat_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              last_o,
   input logic              busy_o,
   input logic              wrap_err_o,
   input logic [1:0]        cur_kind,
   input logic [ADDR_W-1:0] wrap_mask
);
   a_r8_last_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> busy_o);

   a_r8_final_beat_ends: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && last_o && beat_i |=> !busy_o);

   a_r8_mid_beat_continues: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !last_o && beat_i |=> busy_o);

   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !beat_i |=> busy_o && $stable(addr_o) && $stable(last_o));

   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> !busy_o && $stable(addr_o));

   a_r3_fixed_steady: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !last_o && beat_i && cur_kind == 2'd0 |=> $stable(addr_o));

   a_r4_incr_moves: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !last_o && beat_i && cur_kind == 2'd1 |=> addr_o != $past(addr_o));

   a_r5_wrap_in_block: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !last_o && beat_i && cur_kind == 2'd2
      |=> ((addr_o ^ $past(addr_o)) & ~$past(wrap_mask)) == '0);

   a_r6_err_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wrap_err_o);

   a_r6_err_walks_linear: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_err_o |-> cur_kind == 2'd1);
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W)) u_bag_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .beat_i     (beat_i),
   .addr_o     (addr_o),
   .last_o     (last_o),
   .busy_o     (busy_o),
   .wrap_err_o (wrap_err_o),
   .cur_kind   (cur_kind),
   .wrap_mask  (wrap_mask)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] start_addr_i = '0;
   logic [LEN_W-1:0]  len_i = '0;
   logic [2:0]        size_i = '0;
   logic [1:0]        kind_i = '0;
   logic              beat_i = 1'b0;
   logic [ADDR_W-1:0] addr_o;
   logic              last_o;
   logic              busy_o;
   logic              wrap_err_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;   // 125 MHz

   burst_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .len_i(len_i), .size_i(size_i), .kind_i(kind_i), .beat_i(beat_i),
      .addr_o(addr_o), .last_o(last_o), .busy_o(busy_o), .wrap_err_o(wrap_err_o)
   );

   // Behavioural reference model
   bit              m_busy = 0;
   longint unsigned m_addr = 0;
   int              m_rem  = 0;
   int              m_len  = 0;
   int              m_size = 0;
   int              m_kind = 0;   // 0 repeat, 1 linear, 2 folding
   bit              m_err  = 0;

   function automatic longint unsigned model_next();
      longint unsigned bytes, lin, blk, base;
      bytes = 64'd1 << m_size;
      lin   = ((m_addr / bytes) * bytes + bytes) % (64'd1 << ADDR_W);
      if (m_kind == 0) return m_addr;
      if (m_kind == 1) return lin;
      blk  = longint'(m_len + 1) * bytes;
      base = (m_addr / blk) * blk;
      return base + ((m_addr / bytes) * bytes + bytes - base) % blk;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_addr = 0; m_rem = 0; m_err = 0;
      end else if (!m_busy) begin
         if (start_i) begin
            bit legal;
            legal  = (len_i == 1 || len_i == 3 || len_i == 7 || len_i == 15);
            m_busy = 1;
            m_addr = start_addr_i;
            m_rem  = int'(len_i);
            m_len  = int'(len_i);
            m_size = int'(size_i);
            m_err  = (kind_i == 2'd2) && !legal;
            m_kind = (kind_i == 2'd0) ? 0 : ((kind_i == 2'd2 && legal) ? 2 : 1);
         end
      end else if (beat_i) begin
         if (m_rem == 0) begin
            m_busy = 0; m_err = 0;
         end else begin
            m_rem  = m_rem - 1;
            m_addr = model_next();
         end
      end
   end

   function automatic string kind_tag();
      if (!m_busy) return "R9";
      if (m_err) return "R6";
      case (m_kind)
         0: return "R3";
         2: return "R5";
         default: return "R4";
      endcase
   endfunction

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (addr_o !== m_addr[ADDR_W-1:0]) begin
            errors++;
            $display("FAIL %s addr actual %h expected %h", kind_tag(), addr_o, m_addr[ADDR_W-1:0]);
         end
         checks++;
         if (busy_o !== m_busy || last_o !== (m_busy && m_rem == 0)) begin
            errors++;
            $display("FAIL R8 busy/last actual %b/%b expected %b/%b",
                     busy_o, last_o, m_busy, (m_busy && m_rem == 0));
         end
         checks++;
         if (wrap_err_o !== m_err) begin
            errors++;
            $display("FAIL R6 wrap_err actual %b expected %b", wrap_err_o, m_err);
         end
      end
   end

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic expect_val(string req, longint unsigned act, longint unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // Random-strobe burst with stray start pulses
   task automatic burst(input logic [ADDR_W-1:0] a, input int l, input int s, input int k);
      @(negedge clk);
      start_i = 1'b1; start_addr_i = a; len_i = LEN_W'(l); size_i = 3'(s); kind_i = 2'(k);
      step_lfsr(); beat_i = lfsr[0];   // R9: beat in the loading cycle is ignored
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         if (!busy_o) break;
         step_lfsr();
         beat_i  = lfsr[0] | lfsr[3];
         start_i = lfsr[5] & lfsr[7];    // R9: start during a burst is ignored
         start_addr_i = {lfsr, lfsr};
         len_i  = LEN_W'(lfsr[11:8]);
         kind_i = lfsr[2:1];
      end
      start_i = 1'b0; beat_i = 1'b0;
      // R9: idle beats do nothing
      @(negedge clk); beat_i = 1'b1;
      @(negedge clk); beat_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      longint unsigned exp_seq [4] = '{64'h100, 64'h104, 64'h108, 64'h10C};
      repeat (3) @(negedge clk);
      // R1: reset state
      expect_val("R1 busy", busy_o, 0);
      expect_val("R1 last", last_o, 0);
      expect_val("R1 err",  wrap_err_o, 0);
      expect_val("R1 addr", addr_o, 0);
      rst_n = 1'b1;

      // R5: folding example with continuous beats
      @(negedge clk);
      start_i = 1'b1; start_addr_i = 32'h100; len_i = 8'd3; size_i = 3'd2; kind_i = 2'd2;
      @(negedge clk);
      start_i = 1'b0; beat_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         expect_val("R5 folding sequence", addr_o, exp_seq[i]);
         expect_val("R2 last on final beat", last_o, (i == 3));
         @(negedge clk);
      end
      expect_val("R8 busy cleared", busy_o, 0);
      beat_i = 1'b0;

      // R2: single-beat burst
      @(negedge clk);
      start_i = 1'b1; start_addr_i = 32'h40; len_i = 8'd0; size_i = 3'd0; kind_i = 2'd1;
      @(negedge clk);
      start_i = 1'b0;
      expect_val("R2 single beat last", last_o, 1);
      expect_val("R2 single beat busy", busy_o, 1);
      beat_i = 1'b1;
      @(negedge clk);
      beat_i = 1'b0;
      expect_val("R2 single beat retired", busy_o, 0);

      burst(32'h0000_3000, 5, 3, 0);    // R3 repeat
      burst(32'h0000_1003, 4, 2, 1);    // R4 unaligned linear
      burst(32'hFFFF_FFF8, 2, 3, 1);    // R4 address-space rollover
      burst(32'h0000_2038, 7, 3, 2);    // R5 fold mid-block
      burst(32'h0000_0A00, 15, 7, 2);   // R5/R7 128-byte beats
      burst(32'h0000_0005, 1, 0, 2);    // R5/R7 1-byte beats
      burst(32'h0000_0777, 2, 1, 2);    // R6 illegal folding length
      burst(32'h0000_0444, 16, 2, 2);   // R6 17 beats
      burst(32'h0000_0C01, 3, 4, 3);    // R4 code 3 as linear
      burst(32'h0000_5000, 0, 5, 0);    // R2 single repeat
      for (int t = 0; t < 20; t++) begin
         step_lfsr();
         burst({lfsr, lfsr ^ 16'h5A5A}, int'(lfsr[3:0]), int'(lfsr[6:4]), int'(lfsr[9:8]));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule